// File: doc/BRIEF.md
# Half-Bridge PWM Coil Current Controller

This block sequences the two gate drives of a half-bridge that feeds an inductive coil. In switching mode each period opens with a charge phase, in which the high-side switch connects the coil to the supply. Current-sense feedback or a duty limit ends that phase. The block then waits out a dead time and closes the low-side switch, so the coil current freewheels until shortly before the next period begins. In linear mode both switching drives stay off and a single enable puts the high-side device into continuous current-source operation.

The drives work only while the power-state input reports the active state. A 3-bit code selects the switching period. With a 32 MHz system clock the codes cover 0.5 MHz to 4 MHz in 0.5 MHz steps. An external analog loop compares the sensed coil current with a 10-bit target, and the block returns the result as a single "below target" bit. The target value passes through unchanged to the analog side. The mode bit and the frequency code are captured only at period boundaries, so a period that has started always finishes with the settings it started with.

Top module: `hb_pwm_ctrl`

## Requirements
- R1: While reset is low and in the cycle after its release, hs_on_o, ls_on_o and lin_en_o are 0. With active_i held high from release, the first drive is asserted after the second rising clock edge at which active_i is sampled high.
- R2: After a rising edge that samples active_i low, all three drive outputs are 0. On re-activation they remain 0 for two further cycles, so that both switches stay off for at least two cycles.
- R3: In linear mode (mode_pwm_i = 0 captured), lin_en_o = 1 and hs_on_o = ls_on_o = 0 throughout the period, whatever the comparator does.
- R4: In switching mode (mode_pwm_i = 1) the period in clock cycles is chosen by freq_sel_i: codes 0 to 7 give 64, 32, 21, 16, 13, 11, 9 and 8. hs_on_o rises once per period, at counter position 0.
- R5: hs_on_o is asserted at position 0 of each switching period. It drops in the cycle after a rising edge that samples below_target_i = 0 while hs_on_o is 1. The minimum on-time is therefore one cycle.
- R6: hs_on_o stays high for at most period − 2 consecutive cycles, even if below_target_i never falls.
- R7: hs_on_o and ls_on_o are never 1 together. At least two cycles with both at 0 separate a fall of either drive from a rise of the other.
- R8: ls_on_o is 1 from the second cycle after hs_on_o falls up to and including position period − 3. It is 0 in the last two positions of the period.
- R9: A change of freq_sel_i or mode_pwm_i during a period has no effect until the next period boundary.
- R10: target_o equals target_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (32 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| active_i | input | 1 | High while the device is in the active power state |
| mode_pwm_i | input | 1 | 1 = switching mode, 0 = linear mode |
| freq_sel_i | input | 3 | Switching-period code |
| below_target_i | input | 1 | Comparator: sensed current is below target |
| target_i | input | 10 | Current target value |
| target_o | output | 10 | Target passed through to the analog loop |
| hs_on_o | output | 1 | High-side switch drive |
| ls_on_o | output | 1 | Low-side switch drive |
| lin_en_o | output | 1 | High-side linear current-source enable |

## Verification
A comparator sample taken at an edge changes hs_on_o one cycle later. The low side follows three positions after the edge that ended the charge phase. Re-activation gives its first drive two edges after active_i returns high, and a new code or mode applies from the period after the boundary edge. The bench drives every input half a cycle after the falling edge and reads the outputs exactly at the falling edge. A cycle model, written from the requirements and updated on the rising edge, supplies the expected value for every cycle. Directed runs also count period lengths, pulse widths and dead-time gaps edge by edge against the period table.

// File: rtl/hb_pkg.sv
// Shared helpers for the half-bridge controller.
// Assumes the base period is that of the lowest switching frequency (code 0).
package hb_pkg;

    // Period in cycles for a code: base/(code+1), rounded to nearest.
    function automatic int unsigned period_of(int unsigned base, int unsigned code);
        return ((2 * base) / (code + 1) + 1) / 2;
    endfunction

endpackage

// File: rtl/hb_period_gen.sv
// Period generator: run gating after activation, capture of mode and frequency code
// at period boundaries, position counter within the period.
// Assumes every period in the table is at least 4 cycles.
module hb_period_gen #(
    parameter int BASE_PERIOD = 64,
    parameter int FSEL_W      = 3,
    parameter int CNT_W       = $clog2(BASE_PERIOD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              mode_pwm_i,
    input  logic [FSEL_W-1:0] freq_sel_i,
    output logic              run_o,
    output logic              mode_pwm_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W:0]    period_o,
    output logic              last_o,
    output logic              duty_end_o
);
    localparam int NCODES = 1 << FSEL_W;
    localparam int PW     = CNT_W + 1;

    logic [PW-1:0]     per_tab [NCODES];
    logic [1:0]        arm_q;
    logic              mode_q;
    logic [FSEL_W-1:0] fsel_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PW-1:0]     cnt_x;
    logic              load;

    // One table entry per frequency code, computed at elaboration.
    for (genvar g = 0; g < NCODES; g++) begin : g_tab
        assign per_tab[g] = PW'(hb_pkg::period_of(BASE_PERIOD, g));
    end

    assign run_o      = (arm_q == 2'd2);
    assign cnt_x      = {1'b0, cnt_q};
    assign period_o   = per_tab[fsel_q];
    assign last_o     = run_o && (cnt_x == period_o - PW'(1));
    assign duty_end_o = (cnt_x == period_o - PW'(3));
    assign load       = !active_i || !run_o || last_o;
    assign mode_pwm_o = mode_q;
    assign cnt_o      = cnt_q;

    // Activation gate: two active samples must pass before the stage runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            arm_q <= 2'd0;
        end else if (!run_o) begin
            arm_q <= arm_q + 2'd1;
        end
    end

    // Settings capture: only while idle or at the last position of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            fsel_q <= '0;
        end else if (load) begin
            mode_q <= mode_pwm_i;
            fsel_q <= freq_sel_i;
        end
    end

    // Position counter: wraps at period end, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/hb_drive_seq.sv
// Drive sequencer: charge phase, dead time and freewheel phase within one period.
// Assumes the position, period and boundary flags come from hb_period_gen.
module hb_drive_seq #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             mode_pwm_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W:0]   period_i,
    input  logic             last_i,
    input  logic             duty_end_i,
    input  logic             below_i,
    output logic             hs_o,
    output logic             ls_o,
    output logic             lin_o
);
    localparam int PW = CNT_W + 1;

    logic          hs_done_q;
    logic [PW-1:0] ls_from_q;
    logic [PW-1:0] cnt_x;
    logic          pwm_run;

    assign cnt_x   = {1'b0, cnt_i};
    assign pwm_run = run_i && mode_pwm_i;
    assign hs_o    = pwm_run && !hs_done_q;
    assign ls_o    = pwm_run && hs_done_q && (cnt_x >= ls_from_q)
                     && (cnt_x < period_i - PW'(2));
    assign lin_o   = run_i && !mode_pwm_i;

    // End of charge phase: comparator trip or duty limit; low side starts three positions later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_done_q <= 1'b0;
            ls_from_q <= '0;
        end else if (!run_i || last_i) begin
            hs_done_q <= 1'b0;
        end else if (hs_o && (!below_i || duty_end_i)) begin
            hs_done_q <= 1'b1;
            ls_from_q <= cnt_x + PW'(3);
        end
    end

endmodule

// File: rtl/hb_pwm_ctrl.sv
// Half-bridge coil current controller, top level.
// Assumes a 32 MHz clock for the nominal frequency range and a comparator input
// already synchronous to clk.
module hb_pwm_ctrl #(
    parameter int BASE_PERIOD = 64,
    parameter int FSEL_W      = 3,
    parameter int TGT_W       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              mode_pwm_i,
    input  logic [FSEL_W-1:0] freq_sel_i,
    input  logic              below_target_i,
    input  logic [TGT_W-1:0]  target_i,
    output logic [TGT_W-1:0]  target_o,
    output logic              hs_on_o,
    output logic              ls_on_o,
    output logic              lin_en_o
);
    localparam int CNT_W = $clog2(BASE_PERIOD);

    logic             run;
    logic             mode_pwm;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   period;
    logic             last;
    logic             duty_end;

    assign target_o = target_i;

    hb_period_gen #(
        .BASE_PERIOD(BASE_PERIOD),
        .FSEL_W     (FSEL_W),
        .CNT_W      (CNT_W)
    ) u_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active_i),
        .mode_pwm_i(mode_pwm_i),
        .freq_sel_i(freq_sel_i),
        .run_o     (run),
        .mode_pwm_o(mode_pwm),
        .cnt_o     (cnt),
        .period_o  (period),
        .last_o    (last),
        .duty_end_o(duty_end)
    );

    hb_drive_seq #(
        .CNT_W(CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .mode_pwm_i(mode_pwm),
        .cnt_i     (cnt),
        .period_i  (period),
        .last_i    (last),
        .duty_end_i(duty_end),
        .below_i   (below_target_i),
        .hs_o      (hs_on_o),
        .ls_o      (ls_on_o),
        .lin_o     (lin_en_o)
    );

endmodule

// File: rtl/hb_pwm_chk.sv
// Property checker for hb_pwm_ctrl, attached by bind below.
// Assumes reset is held for at least two clock edges.
module hb_pwm_chk #(
    parameter int BASE_PERIOD = 64
) (
    input logic clk,
    input logic rst_n,
    input logic active_i,
    input logic below_target_i,
    input logic hs_on_o,
    input logic ls_on_o,
    input logic lin_en_o
);
    int unsigned hs_len;

    // Length of the current high-side pulse, in completed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !hs_on_o) hs_len <= 0;
        else                    hs_len <= hs_len + 1;
    end

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on_o && ls_on_o));

    // R7
    ls_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on_o) |-> (!$past(hs_on_o) && !$past(hs_on_o, 2)));

    // R7
    hs_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on_o) |-> (!$past(ls_on_o) && !$past(ls_on_o, 2)));

    // R2
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (!hs_on_o && !ls_on_o && !lin_en_o));

    // R3
    lin_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lin_en_o |-> (!hs_on_o && !ls_on_o));

    // R5
    cmp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on_o && !below_target_i) |=> !hs_on_o);

    // R6
    max_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_on_o |-> (hs_len < BASE_PERIOD - 2));

endmodule

bind hb_pwm_ctrl hb_pwm_chk #(.BASE_PERIOD(BASE_PERIOD)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .active_i      (active_i),
    .below_target_i(below_target_i),
    .hs_on_o       (hs_on_o),
    .ls_on_o       (ls_on_o),
    .lin_en_o      (lin_en_o)
);

// File: tb/hb_pwm_ctrl_tb.sv
// Bench for hb_pwm_ctrl: directed corner cases, then seeded random stimulus,
// all compared against a requirement-level cycle model.
module hb_pwm_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       active_i = 1'b0;
    logic       mode_pwm_i = 1'b1;
    logic [2:0] freq_sel_i = 3'd7;
    logic       below_target_i = 1'b1;
    logic [9:0] target_i = 10'd0;
    logic [9:0] target_o;
    logic       hs_on_o, ls_on_o, lin_en_o;

    int n_chk = 0;
    int n_bad = 0;

    hb_pwm_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .active_i(active_i), .mode_pwm_i(mode_pwm_i),
        .freq_sel_i(freq_sel_i), .below_target_i(below_target_i), .target_i(target_i),
        .target_o(target_o), .hs_on_o(hs_on_o), .ls_on_o(ls_on_o), .lin_en_o(lin_en_o)
    );

    always #4 clk = ~clk;

    // Expected period per code (R4).
    function automatic int exp_period(input logic [2:0] c);
        case (c)
            3'd0: return 64;
            3'd1: return 32;
            3'd2: return 21;
            3'd3: return 16;
            3'd4: return 13;
            3'd5: return 11;
            3'd6: return 9;
            default: return 8;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle model from the requirements, advanced at each rising edge.
    int m_arm = 0, m_cnt = 0, m_per = 64, m_lsf = 0;
    bit m_mode = 1'b0, m_done = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_arm = 0; m_cnt = 0; m_done = 0; m_mode = 0; m_per = 64;
        end else if (!active_i || m_arm < 2) begin
            m_arm = active_i ? m_arm + 1 : 0;
            m_cnt = 0; m_done = 0; m_mode = mode_pwm_i; m_per = exp_period(freq_sel_i);
        end else if (m_cnt == m_per - 1) begin
            m_cnt = 0; m_done = 0; m_mode = mode_pwm_i; m_per = exp_period(freq_sel_i);
        end else begin
            if (m_mode && !m_done && (!below_target_i || m_cnt == m_per - 3)) begin
                m_done = 1; m_lsf = m_cnt + 3;
            end
            m_cnt++;
        end
    end

    // Per-cycle comparison at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit run;
            run = (m_arm == 2);
            check(hs_on_o == (run && m_mode && !m_done), "R5 hs model", hs_on_o,
                  run && m_mode && !m_done);
            check(ls_on_o == (run && m_mode && m_done && m_cnt >= m_lsf && m_cnt <= m_per - 3),
                  "R8 ls model", ls_on_o,
                  run && m_mode && m_done && m_cnt >= m_lsf && m_cnt <= m_per - 3);
            check(lin_en_o == (run && !m_mode), "R3 lin model", lin_en_o, run && !m_mode);
            check(target_o == target_i, "R10 target", target_o, target_i);
        end
    end

    task automatic wait_hs_rise();
        bit prev;
        prev = hs_on_o;
        forever begin
            @(negedge clk);
            if (hs_on_o && !prev) break;
            prev = hs_on_o;
        end
    endtask

    // From a rise (position 0) to the next rise: length, HS width, LS count, edges.
    task automatic count_period(output int n, output int w, output int lsc,
                                output int last_hs, output int first_ls, output int last_ls);
        n = 1; w = 1; lsc = 0; last_hs = 0; first_ls = -1; last_ls = -1;
        forever begin
            bit prev_hs;
            prev_hs = hs_on_o;
            @(negedge clk);
            if (hs_on_o && !prev_hs) break;
            if (hs_on_o) begin w++; last_hs = n; end
            if (ls_on_o) begin
                lsc++;
                if (first_ls < 0) first_ls = n;
                last_ls = n;
            end
            n++;
            if (n > 200) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n, w, lsc, lh, fl, ll, dummy;
        dummy = $urandom(32'd24681);
        repeat (5) @(negedge clk);
        check(!hs_on_o && !ls_on_o && !lin_en_o, "R1 reset outputs", hs_on_o + ls_on_o + lin_en_o, 0);
        #1; rst_n = 1'b1; active_i = 1'b1;
        @(negedge clk);
        check(!hs_on_o, "R1 first edge off", hs_on_o, 0);
        @(negedge clk);
        check(hs_on_o, "R1 first drive after two edges", hs_on_o, 1);

        // R4, R6: each code, comparator never trips.
        for (int c = 0; c < 8; c++) begin
            @(negedge clk); #1; freq_sel_i = 3'(c); below_target_i = 1'b1;
            wait_hs_rise(); wait_hs_rise();
            count_period(n, w, lsc, lh, fl, ll);
            check(n == exp_period(3'(c)), "R4 period", n, exp_period(3'(c)));
            check(w == exp_period(3'(c)) - 2, "R6 max duty width", w, exp_period(3'(c)) - 2);
            check(lsc == 0, "R8 no low side at max duty", lsc, 0);
        end

        // R5, R7, R8: immediate trip, two codes.
        for (int k = 0; k < 2; k++) begin
            logic [2:0] c;
            c = (k == 0) ? 3'd7 : 3'd3;
            @(negedge clk); #1; freq_sel_i = c; below_target_i = 1'b0;
            wait_hs_rise(); wait_hs_rise();
            count_period(n, w, lsc, lh, fl, ll);
            check(w == 1, "R5 min on-time", w, 1);
            check(lsc == exp_period(c) - 5, "R8 low side length", lsc, exp_period(c) - 5);
            check(fl - lh - 1 == 2, "R7 dead time hs->ls", fl - lh - 1, 2);
            check(exp_period(c) - 1 - ll == 2, "R7 dead time ls->hs", exp_period(c) - 1 - ll, 2);
        end

        // R9: frequency change mid-period.
        @(negedge clk); #1; freq_sel_i = 3'd0; below_target_i = 1'b1;
        wait_hs_rise(); wait_hs_rise();
        #1; freq_sel_i = 3'd7;
        count_period(n, w, lsc, lh, fl, ll);
        check(n == 64, "R9 running period kept", n, 64);
        count_period(n, w, lsc, lh, fl, ll);
        check(n == 8, "R9 new period applied", n, 8);

        // R9, R3: mode change mid-period.
        #1; freq_sel_i = 3'd0;
        wait_hs_rise(); wait_hs_rise();
        #1; mode_pwm_i = 1'b0;
        begin
            int lin_seen;
            lin_seen = 0;
            for (int i = 0; i < 63; i++) begin
                @(negedge clk);
                if (lin_en_o) lin_seen++;
            end
            check(lin_seen == 0, "R9 mode held to boundary", lin_seen, 0);
            @(negedge clk);
            check(lin_en_o && !hs_on_o && !ls_on_o, "R3 linear after boundary", lin_en_o, 1);
        end
        for (int i = 0; i < 20; i++) begin
            #1; below_target_i = 1'($urandom);
            @(negedge clk);
            check(lin_en_o && !hs_on_o && !ls_on_o, "R3 linear ignores comparator", hs_on_o + ls_on_o, 0);
        end

        // R2: deactivation and restart.
        #1; mode_pwm_i = 1'b1; freq_sel_i = 3'd5; below_target_i = 1'b1;
        repeat (70) @(negedge clk);
        #1; active_i = 1'b0;
        @(negedge clk);
        check(!hs_on_o && !ls_on_o && !lin_en_o, "R2 off after inactive", hs_on_o + ls_on_o + lin_en_o, 0);
        #1; active_i = 1'b1;
        @(negedge clk);
        check(!hs_on_o && !ls_on_o, "R2 second off cycle", hs_on_o + ls_on_o, 0);
        @(negedge clk);
        check(hs_on_o, "R2 restart drive", hs_on_o, 1);

        // Random phase against the model.
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk); #1;
            below_target_i = ($urandom % 16) > 3;
            target_i = 10'($urandom);
            if ($urandom % 50 == 0)  freq_sel_i = 3'($urandom);
            if ($urandom % 300 == 0) mode_pwm_i = ~mode_pwm_i;
            if (!active_i)           active_i = ($urandom % 3) == 0;
            else if ($urandom % 400 == 0) active_i = 1'b0;
        end

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule